// File: doc/BRIEF.md
# Float/Fixed-Point Bidirectional Converter

This block converts a value between IEEE-754 floating point, in single or double precision, and a 32-bit fixed-point number that is either signed two's complement or unsigned. The number of fraction bits comes from a small command field: a size bit picks a base of 32 or 16, and a split immediate (a 4-bit high part and a 1-bit low part) is subtracted from that base. Commands that do not give a usable fraction-bit count are returned as illegal and do nothing else.

Going from float to fixed, the input is scaled by 2^fbits and truncated toward zero. Results outside the 32-bit range saturate and raise an invalid-operation flag. A truncation that drops a nonzero fraction raises an inexact flag. Going from fixed to float, the integer is divided by 2^fbits and rounded to the selected precision. Each command is accepted through a valid/ready handshake and its result is registered. The result appears in the cycle after acceptance and stays in place until the consumer takes it.

Top module: `fxcvt_unit`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or is being consumed in the same cycle. A command accepted at a clock edge sets `out_valid` at that edge. While `out_valid` is high and `out_ready` is low, the outputs hold steady and no new command is accepted. After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The fraction-bit count is fbits = base - imm, where imm = `in_imm_hi`*2 + `in_imm_lo` and base is 32 when `in_wide_base` = 1 and 16 when it is 0.
- R3: A command is illegal when imm = 0 or imm > base. An illegal result has `out_illegal` = 1, `out_data` = 0, and both other flags 0. A legal result has `out_illegal` = 0.
- R4: When `in_to_fixed` = 1, the float value times 2^fbits is truncated toward zero. The 32-bit integer result is placed in `out_data[31:0]`, and `out_data[63:32]` is 0.
- R5: In signed mode (`in_unsigned` = 0), results above 0x7FFFFFFF saturate to 0x7FFFFFFF and results below -2^31 saturate to 0x80000000. Saturation sets `out_invalid`. Exactly -2^31 is a valid result. Infinities saturate according to their sign.
- R6: In unsigned mode (`in_unsigned` = 1), results above 0xFFFFFFFF saturate to 0xFFFFFFFF with `out_invalid`. A negative input gives 0. It sets `out_invalid` only when its truncated magnitude is nonzero.
- R7: A NaN input to float-to-fixed gives 0 with `out_invalid` = 1.
- R8: In float-to-fixed, `out_inexact` is 1 when truncation discards a nonzero fraction or when `out_invalid` is 1. It is 0 for an exact conversion.
- R9: When `in_to_fixed` = 0 and `in_double` = 0, the result is a single-precision value in `out_data[31:0]`, rounded to nearest with ties to even, and `out_data[63:32]` is 0.
- R10: When `in_to_fixed` = 0 and `in_double` = 1, the result is the exact double-precision value of operand / 2^fbits in `out_data[63:0]`.
- R11: Fixed-to-float never sets `out_invalid` or `out_inexact`, and a zero operand gives +0.0.
- R12: A single-precision input and a fixed-point input are both taken from `in_operand[31:0]`. In those cases `in_operand[63:32]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command can be accepted |
| in_to_fixed | input | 1 | 1: float to fixed, 0: fixed to float |
| in_unsigned | input | 1 | 1: unsigned fixed-point, 0: signed |
| in_double | input | 1 | 1: double precision float, 0: single |
| in_wide_base | input | 1 | 1: fraction base 32, 0: base 16 |
| in_imm_hi | input | 4 | Upper part of the fraction immediate |
| in_imm_lo | input | 1 | Lowest bit of the fraction immediate |
| in_operand | input | 64 | Source value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Converted value |
| out_invalid | output | 1 | Invalid operation (saturated or NaN) |
| out_inexact | output | 1 | Result differs from the scaled value |
| out_illegal | output | 1 | Fraction-bit encoding rejected |

## Verification
Float-to-fixed is driven with exact values, values that have a dropped fraction, and values at the edge of the range. The edge cases are -1.0 at 31 fraction bits, which just fits in signed mode, and +1.0 at 31 fraction bits, which just overflows. These separate truncation from saturation and also separate the signed limit from the unsigned limit. Negative inputs in unsigned mode are tried both with a magnitude that truncates to zero and with one that does not, which tells a quiet zero apart from an invalid one. NaN and infinities are also applied. Fixed-to-float is driven with operands whose rounding position holds an exact tie (with even and odd last kept bits) and with an all-ones operand whose rounding carries into the exponent. Garbage in the unused upper operand half and odd and even immediates show that operand placement and fraction decoding are right.

// File: rtl/fxcvt_pkg.sv
package fxcvt_pkg;

    localparam int FIX_W  = 32;
    localparam int FLT_W  = 64;
    localparam int IMM_W  = 4;
    localparam int FB_W   = 6;

    typedef struct packed {
        logic             valid;
        logic [FLT_W-1:0] data;
        logic             invalid;
        logic             inexact;
        logic             illegal;
    } out_st_t;

endpackage

// File: rtl/fxcvt_fbits_dec.sv
module fxcvt_fbits_dec #(
    parameter int IMM_W = 4,
    parameter int FB_W  = 6,
    parameter int BASE_WIDE = 32,
    parameter int BASE_NARROW = 16
) (
    input  logic             wide_base,
    input  logic [IMM_W-1:0] imm_hi,
    input  logic             imm_lo,
    output logic [FB_W-1:0]  fbits,
    output logic             illegal
);

    logic [FB_W-1:0] base;
    logic [FB_W-1:0] imm_ext;

    always_comb begin
        base    = wide_base ? FB_W'(BASE_WIDE) : FB_W'(BASE_NARROW);
        imm_ext = FB_W'({imm_hi, imm_lo});
        illegal = (imm_ext == '0) || (imm_ext > base);
        fbits   = illegal ? '0 : (base - imm_ext);
    end

endmodule

// File: rtl/fxcvt_flt2fix.sv
module fxcvt_flt2fix #(
    parameter int FIX_W = 32,
    parameter int FB_W  = 6
) (
    input  logic             is_double,
    input  logic             is_unsigned,
    input  logic [FB_W-1:0]  fbits,
    input  logic [63:0]      op,
    output logic [FIX_W-1:0] res,
    output logic             invalid,
    output logic             inexact
);

    localparam int DM_W  = 52;
    localparam int SM_W  = 23;
    localparam int M_W   = DM_W + 1;
    localparam int MAG_W = FIX_W + 2;
    localparam int K_W   = 13;
    localparam logic signed [K_W-1:0] K_TOP  = K_W'(FIX_W);
    localparam logic signed [K_W-1:0] K_FRAC = K_W'(DM_W);
    localparam logic [MAG_W-1:0] S_POS_MAX = (MAG_W'(1) << (FIX_W - 1)) - MAG_W'(1);
    localparam logic [MAG_W-1:0] S_NEG_MAX = MAG_W'(1) << (FIX_W - 1);
    localparam logic [MAG_W-1:0] U_MAX     = (MAG_W'(1) << FIX_W) - MAG_W'(1);
    localparam logic [FIX_W-1:0] SAT_SPOS  = {1'b0, {(FIX_W-1){1'b1}}};
    localparam logic [FIX_W-1:0] SAT_SNEG  = {1'b1, {(FIX_W-1){1'b0}}};

    logic                    sgn;
    logic                    exp_max;
    logic                    frac_nz;
    logic [M_W-1:0]          mant;
    logic signed [K_W-1:0]   e;
    logic signed [K_W-1:0]   k;
    logic signed [K_W-1:0]   sh_full;
    logic [5:0]              sh;
    logic [MAG_W-1:0]        mag;
    logic                    dropped;
    logic                    huge;
    logic                    over;
    logic                    is_nan;

    always_comb begin
        // unpack either format onto a common 53-bit significand
        if (is_double) begin
            sgn     = op[63];
            exp_max = &op[62:52];
            frac_nz = |op[51:0];
            mant    = {|op[62:52], op[51:0]};
            e       = (op[62:52] == '0) ? -K_W'(1022)
                                        : $signed({2'b00, op[62:52]}) - K_W'(1023);
        end else begin
            sgn     = op[31];
            exp_max = &op[30:23];
            frac_nz = |op[22:0];
            mant    = {|op[30:23], op[22:0], {(DM_W-SM_W){1'b0}}};
            e       = (op[30:23] == '0) ? -K_W'(126)
                                        : $signed({5'b00000, op[30:23]}) - K_W'(127);
        end
        is_nan  = exp_max && frac_nz;
        k       = e + $signed(K_W'(fbits));
        sh_full = K_FRAC - k;
        sh      = sh_full[5:0];
        huge    = (exp_max && !frac_nz) || (k > K_TOP);

        // magnitude after scaling and truncation toward zero
        if (huge) begin
            mag     = '0;
            dropped = 1'b0;
        end else if (k < 0) begin
            mag     = '0;
            dropped = (mant != '0);
        end else begin
            mag     = MAG_W'(mant >> sh);
            dropped = (mant & ~({M_W{1'b1}} << sh)) != '0;
        end

        // range check against the target integer format
        if (is_unsigned) begin
            over = sgn ? (huge || (mag != '0)) : (huge || (mag > U_MAX));
        end else begin
            over = sgn ? (huge || (mag > S_NEG_MAX)) : (huge || (mag > S_POS_MAX));
        end

        invalid = is_nan || over;
        inexact = invalid || dropped;

        if (is_nan) begin
            res = '0;
        end else if (over) begin
            if (is_unsigned) res = sgn ? '0 : '1;
            else             res = sgn ? SAT_SNEG : SAT_SPOS;
        end else if (sgn && !is_unsigned) begin
            res = FIX_W'(~mag + MAG_W'(1));
        end else if (sgn) begin
            res = '0;
        end else begin
            res = FIX_W'(mag);
        end
    end

endmodule

// File: rtl/fxcvt_fix2flt.sv
module fxcvt_fix2flt #(
    parameter int FIX_W = 32,
    parameter int FB_W  = 6
) (
    input  logic             is_double,
    input  logic             is_unsigned,
    input  logic [FB_W-1:0]  fbits,
    input  logic [FIX_W-1:0] op,
    output logic [63:0]      res
);

    localparam int P_W   = $clog2(FIX_W);
    localparam int EU_W  = FB_W + 2;
    localparam int DE_W  = 11;
    localparam int DM_W  = 52;
    localparam int SE_W  = 8;
    localparam int SM_W  = 23;
    localparam int DROP  = FIX_W - (SM_W + 1);

    logic                   neg;
    logic [FIX_W-1:0]       mag;
    logic [P_W-1:0]         lead;
    logic [FIX_W-1:0]       norm;
    logic signed [EU_W-1:0] e_un;
    logic [DE_W-1:0]        dexp;
    logic [DM_W-1:0]        dfrac;
    logic                   guard;
    logic                   sticky;
    logic                   rnd;
    logic [SM_W:0]          sfrac_sum;
    logic [SE_W-1:0]        sexp;

    always_comb begin
        neg  = !is_unsigned && op[FIX_W-1];
        mag  = neg ? (~op + FIX_W'(1)) : op;
        lead = '0;
        for (int i = 0; i < FIX_W; i++) begin
            if (mag[i]) lead = P_W'(i);
        end
        norm = mag << (P_W'(FIX_W - 1) - lead);
        e_un = $signed(EU_W'(lead)) - $signed(EU_W'(fbits));

        // double: every 32-bit magnitude fits, no rounding
        dexp  = DE_W'({{(DE_W-EU_W){e_un[EU_W-1]}}, e_un} + DE_W'(1023));
        dfrac = {norm[FIX_W-2:0], {(DM_W-FIX_W+1){1'b0}}};

        // single: round to nearest, ties to even
        guard     = norm[DROP-1];
        sticky    = |norm[DROP-2:0];
        rnd       = guard && (sticky || norm[DROP]);
        sfrac_sum = {1'b0, norm[FIX_W-2:DROP]} + (SM_W+1)'(rnd);
        sexp      = SE_W'(e_un) + SE_W'(127) + SE_W'(sfrac_sum[SM_W]);

        if (!norm[FIX_W-1]) begin
            res = '0;
        end else if (is_double) begin
            res = {neg, dexp, dfrac};
        end else begin
            res = {32'b0, neg, sexp, sfrac_sum[SM_W-1:0]};
        end
    end

endmodule

// File: rtl/fxcvt_unit.sv
module fxcvt_unit
    import fxcvt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_to_fixed,
    input  logic             in_unsigned,
    input  logic             in_double,
    input  logic             in_wide_base,
    input  logic [IMM_W-1:0] in_imm_hi,
    input  logic             in_imm_lo,
    input  logic [FLT_W-1:0] in_operand,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [FLT_W-1:0] out_data,
    output logic             out_invalid,
    output logic             out_inexact,
    output logic             out_illegal
);

    logic [FB_W-1:0]  fbits;
    logic             enc_illegal;
    logic [FIX_W-1:0] fix_res;
    logic             fix_invalid;
    logic             fix_inexact;
    logic [FLT_W-1:0] flt_res;
    out_st_t          st_d;
    out_st_t          st_q;

    fxcvt_fbits_dec #(.IMM_W(IMM_W), .FB_W(FB_W)) dec_i (
        .wide_base (in_wide_base),
        .imm_hi    (in_imm_hi),
        .imm_lo    (in_imm_lo),
        .fbits     (fbits),
        .illegal   (enc_illegal)
    );

    fxcvt_flt2fix #(.FIX_W(FIX_W), .FB_W(FB_W)) f2x_i (
        .is_double   (in_double),
        .is_unsigned (in_unsigned),
        .fbits       (fbits),
        .op          (in_operand),
        .res         (fix_res),
        .invalid     (fix_invalid),
        .inexact     (fix_inexact)
    );

    fxcvt_fix2flt #(.FIX_W(FIX_W), .FB_W(FB_W)) x2f_i (
        .is_double   (in_double),
        .is_unsigned (in_unsigned),
        .fbits       (fbits),
        .op          (in_operand[FIX_W-1:0]),
        .res         (flt_res)
    );

    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            if (enc_illegal) begin
                st_d.data    = '0;
                st_d.invalid = 1'b0;
                st_d.inexact = 1'b0;
                st_d.illegal = 1'b1;
            end else if (in_to_fixed) begin
                st_d.data    = {{(FLT_W-FIX_W){1'b0}}, fix_res};
                st_d.invalid = fix_invalid;
                st_d.inexact = fix_inexact;
                st_d.illegal = 1'b0;
            end else begin
                st_d.data    = flt_res;
                st_d.invalid = 1'b0;
                st_d.inexact = 1'b0;
                st_d.illegal = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_data    = st_q.data;
    assign out_invalid = st_q.invalid;
    assign out_inexact = st_q.inexact;
    assign out_illegal = st_q.illegal;

endmodule

// File: rtl/fxcvt_unit_chk.sv
module fxcvt_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_to_fixed,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_data,
    input logic        out_invalid,
    input logic        out_inexact,
    input logic        out_illegal
);

    AST_ACCEPT_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_invalid) && $stable(out_inexact)); // R1

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R1

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_illegal |-> out_data == 64'd0 && !out_invalid && !out_inexact); // R3

    AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> out_data[63:32] == 32'd0 &&
            (out_data[31:0] == 32'h0 || out_data[31:0] == 32'h7FFFFFFF ||
             out_data[31:0] == 32'h80000000 || out_data[31:0] == 32'hFFFFFFFF)); // R5

    AST_INVALID_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> out_inexact); // R8

    AST_FLOAT_NOFLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_ready && !in_to_fixed) |-> !out_invalid && !out_inexact); // R11

endmodule

bind fxcvt_unit fxcvt_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_to_fixed (in_to_fixed),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact),
    .out_illegal (out_illegal)
);

// File: tb/fxcvt_unit_tb_top.sv
`timescale 1ns/1ps
module fxcvt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_to_fixed = 1'b0;
    logic        in_unsigned = 1'b0;
    logic        in_double = 1'b0;
    logic        in_wide_base = 1'b0;
    logic [3:0]  in_imm_hi = 4'd0;
    logic        in_imm_lo = 1'b0;
    logic [63:0] in_operand = 64'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic        out_invalid;
    logic        out_inexact;
    logic        out_illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fxcvt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_to_fixed(in_to_fixed), .in_unsigned(in_unsigned), .in_double(in_double),
        .in_wide_base(in_wide_base), .in_imm_hi(in_imm_hi), .in_imm_lo(in_imm_lo),
        .in_operand(in_operand), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_invalid(out_invalid), .out_inexact(out_inexact),
        .out_illegal(out_illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic tf, input logic uns, input logic dbl, input logic wide,
                         input logic [3:0] i4, input logic i1, input logic [63:0] opnd);
        in_to_fixed  = tf;
        in_unsigned  = uns;
        in_double    = dbl;
        in_wide_base = wide;
        in_imm_hi    = i4;
        in_imm_lo    = i1;
        in_operand   = opnd;
    endtask

    task automatic run_op(input string tag, input logic tf, input logic uns, input logic dbl,
                          input logic wide, input logic [3:0] i4, input logic i1,
                          input logic [63:0] opnd, input logic [63:0] ed,
                          input logic einv, input logic einx, input logic eill);
        @(negedge clk);
        drive(tf, uns, dbl, wide, i4, i1, opnd);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        chk({tag, " data"}, out_data, ed);
        chk({tag, " invalid"}, {63'd0, out_invalid}, {63'd0, einv});
        chk({tag, " inexact"}, {63'd0, out_inexact}, {63'd0, einx});
        chk({tag, " illegal"}, {63'd0, out_illegal}, {63'd0, eill});
    endtask

    task automatic t_reset;
        chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 reset in_ready", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic t_decode;
        // base 32, imm 16 -> 16 fraction bits: 2.5 * 65536
        run_op("R2 fb16", 1, 0, 1, 1, 4'd8, 0, 64'h4004000000000000, 64'h28000, 0, 0, 0);
        // base 32, imm 1 (odd low bit) -> 31 fraction bits: 0.75 * 2^31
        run_op("R2 fb31", 1, 0, 1, 1, 4'd0, 1, 64'h3FE8000000000000, 64'h60000000, 0, 0, 0);
        // base 16, imm 8 -> 8 fraction bits
        run_op("R2 fb8", 1, 0, 1, 0, 4'd4, 0, 64'h4004000000000000, 64'h280, 0, 0, 0);
    endtask

    task automatic t_illegal;
        run_op("R3 imm zero", 1, 0, 1, 1, 4'd0, 0, 64'h4004000000000000, 64'd0, 0, 0, 1);
        run_op("R3 imm over base", 0, 0, 1, 0, 4'd9, 0, 64'h5, 64'd0, 0, 0, 1);
    endtask

    task automatic t_truncate;
        run_op("R4 pos trunc", 1, 0, 1, 0, 4'd8, 0, 64'h4004000000000000, 64'h2, 0, 1, 0);
        run_op("R4 neg trunc", 1, 0, 1, 0, 4'd8, 0, 64'hC004000000000000, 64'hFFFFFFFE, 0, 1, 0);
    endtask

    task automatic t_signed_sat;
        run_op("R5 pos overflow", 1, 0, 1, 1, 4'd0, 1, 64'h3FF0000000000000, 64'h7FFFFFFF, 1, 1, 0);
        run_op("R5 exact min", 1, 0, 1, 1, 4'd0, 1, 64'hBFF0000000000000, 64'h80000000, 0, 0, 0);
        run_op("R5 neg inf", 1, 0, 1, 1, 4'd8, 0, 64'hFFF0000000000000, 64'h80000000, 1, 1, 0);
    endtask

    task automatic t_unsigned;
        run_op("R6 2^31 fits", 1, 1, 1, 1, 4'd0, 1, 64'h3FF0000000000000, 64'h80000000, 0, 0, 0);
        run_op("R6 pos inf", 1, 1, 1, 1, 4'd8, 0, 64'h7FF0000000000000, 64'hFFFFFFFF, 1, 1, 0);
        run_op("R6 neg nonzero", 1, 1, 1, 0, 4'd8, 0, 64'hC004000000000000, 64'h0, 1, 1, 0);
        run_op("R6 neg to zero", 1, 1, 0, 0, 4'd8, 0, 64'h00000000BE800000, 64'h0, 0, 1, 0);
    endtask

    task automatic t_nan;
        run_op("R7 nan", 1, 0, 1, 1, 4'd8, 0, 64'h7FF8000000000000, 64'h0, 1, 1, 0);
    endtask

    task automatic t_inexact;
        // 2.5 with one fraction bit is exactly 5
        run_op("R8 exact", 1, 0, 1, 1, 4'd15, 1, 64'h4004000000000000, 64'h5, 0, 0, 0);
    endtask

    task automatic t_single_round;
        run_op("R9 carry to exp", 0, 1, 0, 0, 4'd8, 0, 64'hFFFFFFFF, 64'h4F800000, 0, 0, 0);
        run_op("R9 tie to even down", 0, 1, 0, 0, 4'd8, 0, 64'h01000001, 64'h4B800000, 0, 0, 0);
        run_op("R9 tie to even up", 0, 1, 0, 0, 4'd8, 0, 64'h01000003, 64'h4B800002, 0, 0, 0);
        run_op("R9 signed min", 0, 0, 0, 1, 4'd0, 1, 64'h80000000, 64'hBF800000, 0, 0, 0);
    endtask

    task automatic t_double_exact;
        run_op("R10 neg half", 0, 0, 1, 1, 4'd15, 1, 64'hFFFFFFFD, 64'hBFF8000000000000, 0, 0, 0);
        run_op("R10 all ones", 0, 1, 1, 0, 4'd8, 0, 64'hFFFFFFFF, 64'h41EFFFFFFFE00000, 0, 0, 0);
    endtask

    task automatic t_zero;
        run_op("R11 zero single", 0, 0, 0, 1, 4'd8, 0, 64'h0, 64'h0, 0, 0, 0);
        run_op("R11 zero double", 0, 0, 1, 1, 4'd8, 0, 64'h0, 64'h0, 0, 0, 0);
    endtask

    task automatic t_placement;
        run_op("R12 single upper ignored", 1, 0, 0, 0, 4'd4, 0, 64'hDEADBEEF3FC00000, 64'h180, 0, 0, 0);
        run_op("R12 fixed upper ignored", 0, 0, 0, 1, 4'd0, 1, 64'h1234567880000000, 64'hBF800000, 0, 0, 0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        out_ready = 1'b0;
        drive(1, 0, 1, 1, 4'd8, 0, 64'h4004000000000000);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R1 presented next cycle", {63'd0, out_valid}, 64'd1);
        chk("R1 blocked while stalled", {63'd0, in_ready}, 64'd0);
        drive(1, 0, 1, 0, 4'd8, 0, 64'hC004000000000000);
        @(negedge clk);
        chk("R1 hold valid", {63'd0, out_valid}, 64'd1);
        chk("R1 hold data", out_data, 64'h28000);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 second accepted", out_data, 64'hFFFFFFFE);
        @(negedge clk);
        chk("R1 drained", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_decode();
        t_illegal();
        t_truncate();
        t_signed_sat();
        t_unsigned();
        t_nan();
        t_inexact();
        t_single_round();
        t_double_exact();
        t_zero();
        t_placement();
        t_handshake();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule